// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block keeps the 8-bit protection status register of a serial memory. It also decides, in every cycle, whether the memory may accept a status write or an array write.

A command decoder ahead of the block gives it:
- one-cycle strobes for write-enable set, write-enable clear and status write, with the status data byte;
- a strobe marking the falling edge of chip select;
- the write-protect pin level.

The array write path gives it the current write address. The block returns the status byte for reads, a status-write permit and an array-write permit for that address.

Write protection has two sources:
- The status register is locked by three things together: the write-enable latch, a lock bit in the register, and the write-protect pin level sampled at the start of the command.
- The array is fenced by a two-bit region field. It protects nothing, the top quarter, the top half or all of the address space.

Persistence across power cycles is modelled by a register that resets to zero.

Top module: `srp_unit`

## Requirements
- R1: The status byte layout is bit 7 lock (SRL), bits 3:2 region field (BPR), bit 1 write-enable latch (WEL), and bits 6:4 and 0 spare. All bits read 0 after reset.
- R2: A write-enable strobe sets WEL and a write-disable strobe clears it. When both come in the same cycle, clear wins.
- R3: While WEL is 0, both permits are 0 and a status write strobe leaves the register unchanged.
- R4: While WEL is 1 and SRL is 0, status writes are permitted whatever the write-protect level.
- R5: While WEL is 1 and SRL is 1, status writes are refused if the sampled write-protect level is low and permitted if it is high.
- R6: The region field protects addresses as follows: 00 none, 01 the top quarter, 10 the top half, 11 every address.
- R7: While WEL is 1, an address outside the protected region gets an array-write permit and an address inside it does not.
- R8: An accepted status write loads bits 7:2 and 0 from the data byte, and WEL keeps its value whatever data bit 1 holds.
- R9: The write-protect level is sampled only on the chip-select-fall strobe. Later changes of the pin do not affect permits until the next such strobe.
- R10: Spare bits are stored and read back and have no effect on either permit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_fall_i | input | 1 | Chip select fell; sample write-protect level |
| wp_i | input | 1 | Write-protect pin level, low protects |
| wren_i | input | 1 | Write-enable strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| wrsr_i | input | 1 | Status write strobe |
| wrsr_data_i | input | 8 | Status write data byte |
| waddr_i | input | ADDR_W | Current array write address |
| status_o | output | 8 | Status byte for reads |
| sr_wr_ok_o | output | 1 | Status write permitted |
| arr_wr_ok_o | output | 1 | Array write permitted at waddr_i |

## Verification
The hardest state to reach is the hardware lock: SRL set, WEL set and a low write-protect level sampled. To get there, the stimulus first writes SRL while SRL is still 0. It then opens a new command with the pin low and tries a status write. The lock must hold even after the pin rises with no new chip-select fall. After that, a command that samples the pin high must release the lock. The region boundaries are exercised at the last address below and the first address inside each protected area.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef struct packed {
    logic       srl;
    logic [2:0] spare_hi;
    logic [1:0] bpr;
    logic       wel;
    logic       spare_lo;
  } status_t;
endpackage

// File: rtl/srp_region_decode.sv
module srp_region_decode #(
  parameter int ADDR_W = 17
) (
  input  logic [1:0]        bpr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  localparam logic [ADDR_W:0] DEPTH   = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] HALF    = DEPTH >> 1;
  localparam logic [ADDR_W:0] QUARTER = DEPTH >> 2;
  localparam logic [ADDR_W:0] TOP_Q   = HALF + QUARTER;

  logic [ADDR_W:0] addr_x;
  assign addr_x = {1'b0, addr_i};

  always_comb begin
    unique case (bpr_i)
      2'b00:   prot_o = 1'b0;
      2'b01:   prot_o = addr_x >= TOP_Q;
      2'b10:   prot_o = addr_x >= HALF;
      default: prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/srp_status_reg.sv
module srp_status_reg
  import srp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_fall_i,
  input  logic       wp_i,
  input  logic       wren_i,
  input  logic       wrdi_i,
  input  logic       wrsr_i,
  input  logic [7:0] wrsr_data_i,
  output status_t    status_o,
  output logic       sr_wr_ok_o
);
  status_t sr_q, sr_nxt;
  logic    wp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wp_q <= 1'b0;
    else if (cs_fall_i) wp_q <= wp_i;
  end

  assign sr_wr_ok_o = sr_q.wel & (~sr_q.srl | wp_q);

  always_comb begin
    sr_nxt = sr_q;
    if (wrsr_i && sr_wr_ok_o) sr_nxt = status_t'(wrsr_data_i);
    // latch only moves on its own strobes
    sr_nxt.wel = sr_q.wel;
    if (wren_i) sr_nxt.wel = 1'b1;
    if (wrdi_i) sr_nxt.wel = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_nxt;
  end

  assign status_o = sr_q;

  p_wren_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wren_i && !wrdi_i |=> status_o.wel);
  p_wrdi_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrdi_i |=> !status_o.wel);
  p_hw_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrsr_i && status_o.srl && !wp_q && !cs_fall_i |=> $stable(status_o[7:2]) && $stable(status_o[0]));
  p_wel_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrsr_i && !wren_i && !wrdi_i |=> status_o.wel == $past(status_o.wel));
endmodule

// File: rtl/srp_unit.sv
module srp_unit
  import srp_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_fall_i,
  input  logic              wp_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic [ADDR_W-1:0] waddr_i,
  output logic [7:0]        status_o,
  output logic              sr_wr_ok_o,
  output logic              arr_wr_ok_o
);
  status_t st;
  logic    in_region;

  srp_status_reg u_sreg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_fall_i   (cs_fall_i),
    .wp_i        (wp_i),
    .wren_i      (wren_i),
    .wrdi_i      (wrdi_i),
    .wrsr_i      (wrsr_i),
    .wrsr_data_i (wrsr_data_i),
    .status_o    (st),
    .sr_wr_ok_o  (sr_wr_ok_o)
  );

  srp_region_decode #(.ADDR_W(ADDR_W)) u_region (
    .bpr_i  (st.bpr),
    .addr_i (waddr_i),
    .prot_o (in_region)
  );

  assign arr_wr_ok_o = st.wel & ~in_region;
  assign status_o    = st;

  p_no_wel_no_permit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[1] |-> !sr_wr_ok_o && !arr_wr_ok_o);
  p_no_wel_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrsr_i && !status_o[1] |=> status_o[7:2] == $past(status_o[7:2]));
  p_all_region_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3:2] == 2'b11 |-> !arr_wr_ok_o);
  p_open_sr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1] && !status_o[7] |-> sr_wr_ok_o);
endmodule

// File: tb/srp_unit_tb.sv
module srp_unit_tb;
  localparam int ADDR_W = 17;
  localparam int NV = 15;
  // {op[2:0], data[7:0], wp, addr[16:0], exp_status[7:0], exp_sr_ok, exp_arr_ok}
  // op: 0 none, 1 wren, 2 wrdi, 3 wrsr
  localparam logic [38:0] VEC [NV] = '{
    {3'd3, 8'hFF, 1'b1, 17'h00000, 8'h00, 1'b0, 1'b0},  // R3 ignored
    {3'd1, 8'h00, 1'b0, 17'h00000, 8'h02, 1'b1, 1'b1},  // R2 R4
    {3'd3, 8'h04, 1'b0, 17'h18000, 8'h06, 1'b1, 1'b0},  // R6 quarter start
    {3'd0, 8'h00, 1'b0, 17'h17FFF, 8'h06, 1'b1, 1'b1},  // R7
    {3'd3, 8'h08, 1'b0, 17'h10000, 8'h0A, 1'b1, 1'b0},  // R6 half start
    {3'd0, 8'h00, 1'b0, 17'h0FFFF, 8'h0A, 1'b1, 1'b1},  // R7
    {3'd3, 8'h8D, 1'b0, 17'h00000, 8'h8F, 1'b0, 1'b0},  // R8 R6 all
    {3'd3, 8'h00, 1'b0, 17'h00000, 8'h8F, 1'b0, 1'b0},  // R5 locked
    {3'd3, 8'h00, 1'b1, 17'h00000, 8'h02, 1'b1, 1'b1},  // R5 wp high
    {3'd3, 8'hF1, 1'b0, 17'h1FFFF, 8'hF3, 1'b0, 1'b1},  // R10
    {3'd2, 8'h00, 1'b0, 17'h1FFFF, 8'hF1, 1'b0, 1'b0},  // R2 R3
    {3'd1, 8'h00, 1'b1, 17'h1FFFF, 8'hF3, 1'b1, 1'b1},  // R10
    {3'd3, 8'h00, 1'b1, 17'h1FFFF, 8'h02, 1'b1, 1'b1},  // R8
    {3'd2, 8'h00, 1'b1, 17'h00000, 8'h00, 1'b0, 1'b0},  // R2
    {3'd3, 8'h02, 1'b1, 17'h00000, 8'h00, 1'b0, 1'b0}   // R8 R3
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_fall = 1'b0, wp = 1'b0, wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0;
  logic [7:0] wdata = '0;
  logic [ADDR_W-1:0] waddr = '0;
  logic [7:0] status;
  logic sr_ok, arr_ok;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  srp_unit #(.ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_fall_i(cs_fall), .wp_i(wp),
    .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr), .wrsr_data_i(wdata),
    .waddr_i(waddr), .status_o(status), .sr_wr_ok_o(sr_ok), .arr_wr_ok_o(arr_ok)
  );

  task automatic check(input string req, input logic [7:0] est, input logic esr, input logic earr);
    #1;
    n_run++;
    if (status !== est || sr_ok !== esr || arr_ok !== earr) begin
      n_fail++;
      $display("FAIL %s: status=%h sr=%b arr=%b expected status=%h sr=%b arr=%b",
               req, status, sr_ok, arr_ok, est, esr, earr);
    end
  endtask

  task automatic command(input logic [2:0] op, input logic [7:0] d, input logic wpl,
                         input logic [ADDR_W-1:0] a);
    @(negedge clk); wp = wpl; cs_fall = 1'b1;
    @(negedge clk); cs_fall = 1'b0;
    wren = (op == 3'd1); wrdi = (op == 3'd2); wrsr = (op == 3'd3); wdata = d;
    @(negedge clk); wren = 0; wrdi = 0; wrsr = 0; waddr = a;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      command(VEC[i][38:36], VEC[i][35:28], VEC[i][27], VEC[i][26:10]);
      check($sformatf("R2-table step %0d", i), VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end
    // R9: lock, then pin rises without new chip-select fall
    command(3'd1, 8'h00, 1'b1, 17'h0);
    command(3'd3, 8'h80, 1'b1, 17'h0);
    check("R9 setup", 8'h82, 1'b1, 1'b1);
    @(negedge clk); wp = 1'b0; cs_fall = 1'b1;
    @(negedge clk); cs_fall = 1'b0; wp = 1'b1;
    @(negedge clk); wrsr = 1'b1; wdata = 8'h00;
    @(negedge clk); wrsr = 1'b0;
    check("R9 pin rise ignored", 8'h82, 1'b0, 1'b1);
    command(3'd3, 8'h00, 1'b1, 17'h0);
    check("R9 resample high", 8'h02, 1'b1, 1'b1);
    // R2: both strobes together, clear wins
    @(negedge clk); wren = 1'b1; wrdi = 1'b1;
    @(negedge clk); wren = 1'b0; wrdi = 1'b0;
    check("R2 clear wins", 8'h00, 1'b0, 1'b0);
    // R6 quarter boundary: last unprotected address
    command(3'd1, 8'h00, 1'b0, 17'h0);
    command(3'd3, 8'h04, 1'b0, 17'h17FFF);
    check("R6 below quarter", 8'h06, 1'b1, 1'b1);
    // R1: reset clears everything
    command(3'd3, 8'hFD, 1'b0, 17'h0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", 8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule